// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands and reports, all at once, whether the first is below, equal to or above the second. It is built from identical 4-bit slices. Each slice has three status inputs (below, equal, above) that carry the verdict of the less significant part of the operands. It also has three status outputs that carry the verdict up to the next slice.

A slice settles its own verdict from its own nibbles when they differ. It forwards the incoming status unchanged when they are equal. Nibble equality is formed as the AND of per-bit XNOR terms.

The wrapper chains `SLICES` slices from least to most significant and takes the result from the top slice. The bottom slice is seeded with "equal" true and the other two inputs false. The logic is purely combinational, with no clock.

Top module: `cmp_wide`

## Requirements
- R1: `lt_o` is 1 exactly when `a_i` is below `b_i`, both read as unsigned binary numbers with bit 0 least significant.
- R2: `eq_o` is 1 exactly when every bit of `a_i` matches the same bit of `b_i`.
- R3: `gt_o` is 1 exactly when `a_i` is above `b_i` as unsigned numbers.
- R4: For every operand pair exactly one of `lt_o`, `eq_o`, `gt_o` is 1. Inside each slice, one-hot status inputs give one-hot status outputs.
- R5: When the nibbles of a slice differ, that slice's outputs are set by its own nibbles alone. The verdict from less significant nibbles has no effect, so the most significant differing nibble (bits [4k+3:4k]) decides the result.
- R6: When the nibbles of a slice are equal, the slice passes its three status inputs to its outputs unchanged. The result of a pair whose upper nibbles agree therefore follows the lower nibbles.
- R7: The chain is seeded as equal. Operands that agree in every bit, including all-zero and all-ones, give `eq_o`=1 with `lt_o`=`gt_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*SLICES | First unsigned operand |
| b_i | input | 4*SLICES | Second unsigned operand |
| lt_o | output | 1 | a_i below b_i |
| eq_o | output | 1 | a_i equal to b_i |
| gt_o | output | 1 | a_i above b_i |

## Verification
The two-slice chain is swept over all 65,536 operand pairs. This sets every combination of "high nibbles decide" against "low nibbles decide" and distinguishes a broken seed from a broken pass-through. Directed pairs then check specific cases:
- High nibbles that disagree with opposing low nibbles, which separate R5 from a design that lets lower status leak through.
- Equal high nibbles, where only a correct forward path gives the right answer.
- All-zero and all-ones operands, which expose a wrong seed.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int NIB = 4;

  typedef struct packed {
    logic below;
    logic same;
    logic above;
  } verdict_t;

  localparam verdict_t SEED = '{below: 1'b0, same: 1'b1, above: 1'b0};

  // scan from the top bit; first difference settles the order
  function automatic logic nib_above(input logic [NIB-1:0] x, input logic [NIB-1:0] y);
    logic found;
    logic res;
    found = 1'b0;
    res   = 1'b0;
    for (int i = NIB - 1; i >= 0; i--) begin
      if (!found && (x[i] != y[i])) begin
        found = 1'b1;
        res   = x[i];
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/cmp_nib_match.sv
module cmp_nib_match
  import cmp_pkg::*;
(
  input  logic [NIB-1:0] x_i,
  input  logic [NIB-1:0] y_i,
  output logic           match_o
);
  logic [NIB-1:0] bit_same;

  for (genvar g = 0; g < NIB; g++) begin : g_xnor
    assign bit_same[g] = ~(x_i[g] ^ y_i[g]);
  end

  assign match_o = &bit_same;

  always_comb begin
    // R2
    nib_match_chk: assert (match_o == (x_i == y_i));
  end
endmodule

// File: rtl/cmp_nib_order.sv
module cmp_nib_order
  import cmp_pkg::*;
(
  input  logic [NIB-1:0] x_i,
  input  logic [NIB-1:0] y_i,
  output logic           above_o,
  output logic           below_o
);
  assign above_o = nib_above(x_i, y_i);
  assign below_o = nib_above(y_i, x_i);

  always_comb begin
    // R4
    nib_order_excl_chk: assert (!(above_o && below_o));
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
(
  input  logic [NIB-1:0] x_i,
  input  logic [NIB-1:0] y_i,
  input  logic           lt_in,
  input  logic           eq_in,
  input  logic           gt_in,
  output logic           lt_out,
  output logic           eq_out,
  output logic           gt_out
);
  logic nib_equal;
  logic nib_gt;
  logic nib_lt;
  verdict_t from_below;
  verdict_t result;

  cmp_nib_match u_match (.x_i(x_i), .y_i(y_i), .match_o(nib_equal));
  cmp_nib_order u_order (.x_i(x_i), .y_i(y_i), .above_o(nib_gt), .below_o(nib_lt));

  assign from_below = '{below: lt_in, same: eq_in, above: gt_in};

  always_comb begin
    if (nib_equal) result = from_below;
    else           result = '{below: nib_lt, same: 1'b0, above: nib_gt};
  end

  assign lt_out = result.below;
  assign eq_out = result.same;
  assign gt_out = result.above;

  always_comb begin
    // R4
    slice_onehot_chk: assert (!$onehot({lt_in, eq_in, gt_in}) || $onehot({lt_out, eq_out, gt_out}));
    // R6
    slice_pass_chk: assert ((x_i != y_i) || ({lt_out, eq_out, gt_out} == {lt_in, eq_in, gt_in}));
    // R5
    slice_local_chk: assert ((x_i == y_i) ||
                             ({lt_out, eq_out, gt_out} == {x_i < y_i, 1'b0, x_i > y_i}));
  end
endmodule

// File: rtl/cmp_wide.sv
module cmp_wide
  import cmp_pkg::*;
#(
  parameter int SLICES = 2,
  localparam int WIDTH = NIB * SLICES
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o
);
  logic [SLICES:0] lt_c;
  logic [SLICES:0] eq_c;
  logic [SLICES:0] gt_c;

  assign lt_c[0] = SEED.below;
  assign eq_c[0] = SEED.same;
  assign gt_c[0] = SEED.above;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cmp_slice u_slice (
      .x_i   (a_i[s*NIB +: NIB]),
      .y_i   (b_i[s*NIB +: NIB]),
      .lt_in (lt_c[s]),
      .eq_in (eq_c[s]),
      .gt_in (gt_c[s]),
      .lt_out(lt_c[s+1]),
      .eq_out(eq_c[s+1]),
      .gt_out(gt_c[s+1])
    );
  end

  assign lt_o = lt_c[SLICES];
  assign eq_o = eq_c[SLICES];
  assign gt_o = gt_c[SLICES];

  always_comb begin
    // R4
    wide_onehot_chk: assert ($onehot({lt_o, eq_o, gt_o}));
    // R1
    wide_lt_chk: assert (lt_o == (a_i < b_i));
    // R3
    wide_gt_chk: assert (gt_o == (a_i > b_i));
    // R7
    wide_seed_chk: assert ((a_i != b_i) || eq_o);
  end
endmodule

// File: tb/sim_cmp_wide.sv
module sim_cmp_wide;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] a, b;
  logic lt, eq, gt;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_wide #(.SLICES(2)) u0 (.a_i(a), .b_i(b), .lt_o(lt), .eq_o(eq), .gt_o(gt));

  task automatic chk(input string tag, input logic el, input logic ee, input logic eg);
    vectors++;
    if ({lt, eq, gt} !== {el, ee, eg}) begin
      miscompares++;
      $display("FAIL %s a=%02h b=%02h actual lt/eq/gt=%b%b%b expected %b%b%b",
               tag, a, b, lt, eq, gt, el, ee, eg);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y);
    @(posedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R7 reset zeros", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(8'(i), 8'(j));
        // R1 R2 R3 R4: native relational reference
        chk("R1/R2/R3 sweep", i < j, i == j, i > j);
      end
    end
  endtask

  task automatic t_high_decides();
    apply(8'h2F, 8'h30); chk("R5 high below, low above", 1'b1, 1'b0, 1'b0);
    apply(8'h90, 8'h8F); chk("R5 high above, low below", 1'b0, 1'b0, 1'b1);
    apply(8'h10, 8'h01); chk("R5 high wins over low", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_low_passes();
    apply(8'h57, 8'h58); chk("R6 equal high, low below", 1'b1, 1'b0, 1'b0);
    apply(8'hA9, 8'hA3); chk("R6 equal high, low above", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_seed();
    apply(8'h00, 8'h00); chk("R7 all zero", 1'b0, 1'b1, 1'b0);
    apply(8'hFF, 8'hFF); chk("R7 all ones", 1'b0, 1'b1, 1'b0);
    apply(8'hFF, 8'h00); chk("R3 max vs min", 1'b0, 1'b0, 1'b1);
    apply(8'h00, 8'hFF); chk("R1 min vs max", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    a = 8'h00;
    b = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high_decides();
    t_low_passes();
    t_seed();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule